// File: doc/BRIEF.md
# UART Supplementary Control and Wake-Up Logic

This block sits beside the serial core of a 16550-style UART. It holds one supplementary control word on a simple register bus. It watches the receive, clear-to-send and data-set-ready pins for the falling edge that means a remote device wants attention, and records that edge in a sticky wake-up status bit. That bit is kept out of the interrupt identification encoding and is readable only from a separate status word.

The same control word does three more jobs. It chooses whether the transmit-holding interrupt follows its normal source or waits until both the transmit FIFO and the transmit shift register are empty. It gates the data-set-ready change interrupt. It selects the DMA mode, taken either from the FIFO control bit or from a two-bit field of its own. The mode decides which of two request lines serves transmit and which serves receive.

Two single-bit enables for a trigger granularity of one are passed out as levels to the FIFO trigger logic. The FIFOs, the serial engine and the interrupt encoder all live outside this block.

Top module: `uart_supctl`

## Requirements
- R1: After reset the control word reads 0x0000, the status word reads 0x0000, and `irq_o`, `dma_req`, `wake_sts`, `rx_gran1` and `tx_gran1` are all 0.
- R2: A write with `bus_addr`=0 stores `bus_wdata[7:0]` as the control word. A read at address 0 returns that byte in bits 7:0, and bits 15:8 always read 0. Writes with `bus_addr`=1 change nothing. A read at address 1 returns the status word, with the wake-up status in bit 1 and 0 in every other bit.
- R3: `rx_gran1` equals control bit 7 and `tx_gran1` equals control bit 6.
- R4: With control bit 5 at 1, `dsr_change` high drives `irq_o` high one clock later. With bit 5 at 0, `dsr_change` has no effect on `irq_o`.
- R5: With control bit 4 at 1, a falling edge on `rx_pin`, `cts_pin` or `dsr_pin` sets `wake_sts` on the third rising clock edge after the pin change. Each pin passes through a two-flop synchronizer, then edge detection, then the status register.
- R6: `wake_sts` is not set by a falling edge while control bit 4 is 0, and never by a rising edge.
- R7: `wake_sts` stays set until a control write carries bit 4 = 0, which clears it on that clock edge. A falling edge that reaches the detector in the same cycle as that write is dropped.
- R8: With control bit 3 at 0, the transmit-holding source is `thr_irq_raw`. With bit 3 at 1, the source is `tx_fifo_empty & tx_shift_empty`. Either way the source reaches `irq_o` one clock later.
- R9: With control bit 0 at 0, the DMA mode is 0 when `fcr_dma_sel` is 0 and 1 when it is 1. With bit 0 at 1, the mode is control bits 2:1 and `fcr_dma_sel` is ignored.
- R10: The DMA mode maps the requests onto `dma_req` one clock later. Mode 0 gives 00. Mode 1 gives `dma_req[0]`=`tx_fifo_req` and `dma_req[1]`=`rx_fifo_req`. Mode 2 gives `dma_req[0]`=`rx_fifo_req`. Mode 3 gives `dma_req[0]`=`tx_fifo_req`. Any line a mode does not name is 0.
- R11: `irq_o` is registered and equals the OR of `wake_sts`, the gated DSR source and the qualified transmit-holding source, all taken one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Word select: 0 = control, 1 = status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected word |
| fcr_dma_sel | input | 1 | DMA select bit from the FIFO control register |
| rx_pin | input | 1 | Receive pin (asynchronous) |
| cts_pin | input | 1 | Clear-to-send pin (asynchronous) |
| dsr_pin | input | 1 | Data-set-ready pin (asynchronous) |
| dsr_change | input | 1 | DSR delta flag from the modem status logic |
| thr_irq_raw | input | 1 | Normal transmit-holding interrupt source |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_fifo_req | input | 1 | Transmit FIFO level request |
| rx_fifo_req | input | 1 | Receive FIFO level request |
| dma_req | output | 2 | DMA request lines |
| rx_gran1 | output | 1 | Receive trigger granularity-of-one enable |
| tx_gran1 | output | 1 | Transmit trigger granularity-of-one enable |
| wake_sts | output | 1 | Sticky wake-up status |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
Control writes take effect on the clock edge that samples them. Read data, and the granularity outputs, follow the stored word at once. `irq_o` and `dma_req` lag their inputs by exactly one edge. A wake-up pin edge needs three edges to reach `wake_sts` and a fourth to reach `irq_o`.

The bench drives every input just after a falling clock edge. It advances a counted number of rising edges and samples on the next falling edge. For the wake-up path it checks that status is still clear after two edges and set after the third. The same-cycle race is built by timing the clearing write to land on the edge where the detector fires. A later re-enable then confirms that the edge is lost, not postponed.

// File: rtl/supctl_pkg.sv
package supctl_pkg;
    localparam int CTL_W         = 8;
    localparam int BIT_RX_GRAN   = 7;
    localparam int BIT_TX_GRAN   = 6;
    localparam int BIT_DSR_EN    = 5;
    localparam int BIT_WAKE_EN   = 4;
    localparam int BIT_THR_EMPTY = 3;
    localparam int BIT_MODE_HI   = 2;
    localparam int BIT_MODE_LO   = 1;
    localparam int BIT_MODE_SRC  = 0;
    localparam int STS_WAKE_BIT  = 1;
    localparam int NUM_PINS      = 3;

    typedef enum logic [1:0] {
        DMA_OFF     = 2'd0,
        DMA_SPLIT   = 2'd1,
        DMA_RX_ONLY = 2'd2,
        DMA_TX_ONLY = 2'd3
    } dma_mode_e;
endpackage

// File: rtl/supctl_sync.sv
module supctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] fall_o
);
    localparam int LAST = STAGES;

    // stage 0..STAGES-1 synchronize, stage LAST holds the previous value
    logic [WIDTH-1:0] stg_d [LAST+1];
    logic [WIDTH-1:0] stg_q [LAST+1];

    always_comb begin
        stg_d[0] = pin_i;
        for (int i = 1; i <= LAST; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '1;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign fall_o = stg_q[LAST] & ~stg_q[LAST-1];
endmodule

// File: rtl/supctl_dma_map.sv
module supctl_dma_map
    import supctl_pkg::*;
(
    input  logic       src_ctl,
    input  logic [1:0] ctl_mode,
    input  logic       fcr_sel,
    input  logic       tx_req,
    input  logic       rx_req,
    output logic [1:0] req_d
);
    dma_mode_e mode;

    always_comb begin
        if (src_ctl) mode = dma_mode_e'(ctl_mode);
        else         mode = fcr_sel ? DMA_SPLIT : DMA_OFF;

        req_d = 2'b00;
        unique case (mode)
            DMA_OFF:     req_d = 2'b00;
            DMA_SPLIT:   req_d = {rx_req, tx_req};
            DMA_RX_ONLY: req_d = {1'b0, rx_req};
            DMA_TX_ONLY: req_d = {1'b0, tx_req};
            default:     req_d = 2'b00;
        endcase
    end
endmodule

// File: rtl/uart_supctl.sv
module uart_supctl
    import supctl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fcr_dma_sel,
    input  logic              rx_pin,
    input  logic              cts_pin,
    input  logic              dsr_pin,
    input  logic              dsr_change,
    input  logic              thr_irq_raw,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    input  logic              tx_fifo_req,
    input  logic              rx_fifo_req,
    output logic [1:0]        dma_req,
    output logic              rx_gran1,
    output logic              tx_gran1,
    output logic              wake_sts,
    output logic              irq_o
);
    localparam int RSV_W = DATA_W - CTL_W;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic             wake;
        logic             irq;
        logic [1:0]       dma;
    } st_t;

    st_t st_d, st_q;
    logic [CTL_W-1:0]    ctl_q;
    logic [NUM_PINS-1:0] pin_fall;
    logic [1:0]          dma_next;
    logic                ctl_wr;
    logic                thr_src;
    logic                dsr_src;

    supctl_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({dsr_pin, cts_pin, rx_pin}),
        .fall_o (pin_fall)
    );

    supctl_dma_map u_dma (
        .src_ctl  (ctl_q[BIT_MODE_SRC]),
        .ctl_mode (ctl_q[BIT_MODE_HI:BIT_MODE_LO]),
        .fcr_sel  (fcr_dma_sel),
        .tx_req   (tx_fifo_req),
        .rx_req   (rx_fifo_req),
        .req_d    (dma_next)
    );

    assign ctl_q = st_q.ctl;

    always_comb begin
        st_d    = st_q;
        ctl_wr  = bus_wr && (bus_addr == 1'b0);
        thr_src = ctl_q[BIT_THR_EMPTY] ? (tx_fifo_empty & tx_shift_empty) : thr_irq_raw;
        dsr_src = ctl_q[BIT_DSR_EN] & dsr_change;

        if (ctl_wr) begin
            st_d.ctl = bus_wdata[CTL_W-1:0];
        end

        // clearing write wins over an edge arriving in the same cycle
        if (ctl_wr && !bus_wdata[BIT_WAKE_EN]) begin
            st_d.wake = 1'b0;
        end else if (ctl_q[BIT_WAKE_EN] && (|pin_fall)) begin
            st_d.wake = 1'b1;
        end

        st_d.irq = st_q.wake | dsr_src | thr_src;
        st_d.dma = dma_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == 1'b0) begin
            bus_rdata = {{RSV_W{1'b0}}, st_q.ctl};
        end else begin
            bus_rdata[STS_WAKE_BIT] = st_q.wake;
        end
    end

    assign dma_req  = st_q.dma;
    assign rx_gran1 = st_q.ctl[BIT_RX_GRAN];
    assign tx_gran1 = st_q.ctl[BIT_TX_GRAN];
    assign wake_sts = st_q.wake;
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/uart_supctl_chk.sv
module uart_supctl_chk
    import supctl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CTL_W-1:0]  ctl_q,
    input logic              fcr_dma_sel,
    input logic              wake_sts,
    input logic              irq_o,
    input logic [1:0]        dma_req
);
    logic clr_wr;
    assign clr_wr = bus_wr && !bus_addr && !bus_wdata[BIT_WAKE_EN];

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 1'b0) |-> (bus_rdata[DATA_W-1:CTL_W] == '0));

    a_r6_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_sts) |-> $past(ctl_q[BIT_WAKE_EN]));

    a_r7_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sts && !clr_wr) |=> wake_sts);

    a_r7_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !wake_sts);

    a_r11_irq_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
        wake_sts |=> irq_o);

    a_r10_mode0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[BIT_MODE_SRC] && !fcr_dma_sel) |=> (dma_req == 2'b00));

    a_r10_line1_split_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[BIT_MODE_SRC] && ctl_q[BIT_MODE_HI]) |=> !dma_req[1]);
endmodule

bind uart_supctl uart_supctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ctl_q       (ctl_q),
    .fcr_dma_sel (fcr_dma_sel),
    .wake_sts    (wake_sts),
    .irq_o       (irq_o),
    .dma_req     (dma_req)
);

// File: tb/uart_supctl_bench.sv
module uart_supctl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        fcr_dma_sel, rx_pin, cts_pin, dsr_pin, dsr_change;
    logic        thr_irq_raw, tx_fifo_empty, tx_shift_empty, tx_fifo_req, rx_fifo_req;
    logic [1:0]  dma_req;
    logic        rx_gran1, tx_gran1, wake_sts, irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_supctl u_uart_supctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fcr_dma_sel(fcr_dma_sel),
        .rx_pin(rx_pin), .cts_pin(cts_pin), .dsr_pin(dsr_pin), .dsr_change(dsr_change),
        .thr_irq_raw(thr_irq_raw), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty), .tx_fifo_req(tx_fifo_req),
        .rx_fifo_req(rx_fifo_req), .dma_req(dma_req), .rx_gran1(rx_gran1),
        .tx_gran1(tx_gran1), .wake_sts(wake_sts), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = '0; fcr_dma_sel = 0;
        rx_pin = 1; cts_pin = 1; dsr_pin = 1; dsr_change = 0; thr_irq_raw = 0;
        tx_fifo_empty = 0; tx_shift_empty = 0; tx_fifo_req = 0; rx_fifo_req = 0;
        step(3);
        rst_n = 1'b1;
        step(1);
        rd(1'b0, v); check("R1", "ctl word", v, 16'h0000);
        rd(1'b1, v); check("R1", "status word", v, 16'h0000);
        check("R1", "irq", irq_o, 0);
        check("R1", "dma", dma_req, 0);
        check("R1", "wake", wake_sts, 0);
        check("R1", "grans", {rx_gran1, tx_gran1}, 0);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(1'b0, 16'hA5C3);
        rd(1'b0, v); check("R2", "reserved bits masked", v, 16'h00C3);
        wr(1'b1, 16'hFFFF);
        rd(1'b0, v); check("R2", "status write ignored", v, 16'h00C3);
        rd(1'b1, v); check("R2", "status word", v, 16'h0000);
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); check("R2", "all ones", v, 16'h00FF);
        check("R3", "both grans", {rx_gran1, tx_gran1}, 2'b11);
        wr(1'b0, 16'h0040);
        check("R3", "tx gran only", {rx_gran1, tx_gran1}, 2'b01);
        wr(1'b0, 16'h0080);
        check("R3", "rx gran only", {rx_gran1, tx_gran1}, 2'b10);
        wr(1'b0, 16'h0000);
        step(1);
    endtask

    task automatic t_dsr_irq;
        wr(1'b0, 16'h0020);
        dsr_change = 1; step(1);
        check("R4", "dsr irq enabled", irq_o, 1);
        dsr_change = 0; step(1);
        check("R4", "dsr irq drops", irq_o, 0);
        wr(1'b0, 16'h0000);
        dsr_change = 1; step(1);
        check("R4", "dsr irq gated", irq_o, 0);
        dsr_change = 0; step(1);
    endtask

    task automatic t_wake_pin(input int which, input string nm);
        logic [15:0] v;
        wr(1'b0, 16'h0010);
        if (which == 0) rx_pin = 0; else if (which == 1) cts_pin = 0; else dsr_pin = 0;
        step(2);
        check("R5", {nm, " wake not yet after 2 edges"}, wake_sts, 0);
        step(1);
        check("R5", {nm, " wake after 3 edges"}, wake_sts, 1);
        rd(1'b1, v); check("R2", {nm, " status bit1"}, v, 16'h0002);
        step(1);
        check("R11", {nm, " irq from wake"}, irq_o, 1);
        rx_pin = 1; cts_pin = 1; dsr_pin = 1;
        step(4);
        check("R7", {nm, " wake sticky"}, wake_sts, 1);
        wr(1'b0, 16'h0010);
        check("R7", {nm, " bit4=1 write keeps"}, wake_sts, 1);
        wr(1'b0, 16'h0000);
        check("R7", {nm, " clear on bit4=0"}, wake_sts, 0);
        step(1);
        check("R11", {nm, " irq drops after clear"}, irq_o, 0);
    endtask

    task automatic t_wake_disabled;
        wr(1'b0, 16'h0000);
        cts_pin = 0; step(4);
        check("R6", "no wake when disabled", wake_sts, 0);
        wr(1'b0, 16'h0010);
        cts_pin = 1; step(4);
        check("R6", "rising edge ignored", wake_sts, 0);
        check("R6", "no irq", irq_o, 0);
    endtask

    task automatic t_wake_race;
        wr(1'b0, 16'h0010);
        dsr_pin = 0; step(4); dsr_pin = 1; step(4);
        check("R7", "race setup wake set", wake_sts, 1);
        rx_pin = 0;
        step(2);
        wr(1'b0, 16'h0000);
        check("R7", "edge dropped on clear", wake_sts, 0);
        wr(1'b0, 16'h0010);
        step(3);
        check("R7", "dropped edge not replayed", wake_sts, 0);
        rx_pin = 1;
        wr(1'b0, 16'h0000);
        step(3);
    endtask

    task automatic t_thr;
        wr(1'b0, 16'h0008);
        thr_irq_raw = 1; tx_fifo_empty = 1; tx_shift_empty = 0; step(1);
        check("R8", "qualified, shift busy", irq_o, 0);
        tx_shift_empty = 1; step(1);
        check("R8", "qualified, both empty", irq_o, 1);
        wr(1'b0, 16'h0000);
        thr_irq_raw = 1; tx_fifo_empty = 0; tx_shift_empty = 0; step(1);
        check("R8", "normal raw high", irq_o, 1);
        thr_irq_raw = 0; tx_fifo_empty = 1; tx_shift_empty = 1; step(1);
        check("R8", "normal raw low", irq_o, 0);
        tx_fifo_empty = 0; tx_shift_empty = 0;
    endtask

    task automatic t_dma;
        wr(1'b0, 16'h0000);
        fcr_dma_sel = 0; tx_fifo_req = 1; rx_fifo_req = 1; step(1);
        check("R9", "fcr 0 -> mode0", dma_req, 2'b00);
        fcr_dma_sel = 1; step(1);
        check("R10", "fcr 1 -> mode1 both", dma_req, 2'b11);
        rx_fifo_req = 0; step(1);
        check("R10", "mode1 tx on line0", dma_req, 2'b01);
        tx_fifo_req = 0; rx_fifo_req = 1; step(1);
        check("R10", "mode1 rx on line1", dma_req, 2'b10);
        wr(1'b0, 16'h0001);
        tx_fifo_req = 1; rx_fifo_req = 1; step(1);
        check("R9", "ctl mode0 overrides fcr", dma_req, 2'b00);
        wr(1'b0, 16'h0005);
        tx_fifo_req = 1; rx_fifo_req = 0; step(1);
        check("R10", "mode2 ignores tx", dma_req, 2'b00);
        tx_fifo_req = 0; rx_fifo_req = 1; step(1);
        check("R10", "mode2 rx on line0", dma_req, 2'b01);
        wr(1'b0, 16'h0007);
        tx_fifo_req = 0; rx_fifo_req = 1; step(1);
        check("R10", "mode3 ignores rx", dma_req, 2'b00);
        tx_fifo_req = 1; step(1);
        check("R10", "mode3 tx on line0", dma_req, 2'b01);
        fcr_dma_sel = 0;
        wr(1'b0, 16'h0003);
        step(1);
        check("R9", "ctl mode1 with fcr 0", dma_req, 2'b11);
        tx_fifo_req = 0; rx_fifo_req = 0;
        wr(1'b0, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_dsr_irq();
        t_wake_pin(0, "rx");
        t_wake_pin(1, "cts");
        t_wake_pin(2, "dsr");
        t_wake_disabled();
        t_wake_race();
        t_thr();
        t_dma();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule